// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel ports, called A and B, and moves data between them in either direction. Each direction has its own storage register with its own clock. The A-to-B register samples the A port. The B-to-A register samples the B port. Together, an active-low output enable and a direction input decide which port is driven, if either.

For each direction, a select input chooses the value sent to the driven port. It is either the live value arriving at the opposite port, or the value held in that direction's register. The registers keep sampling whatever the drive state is. This means data can be captured while both ports are isolated, or captured from the port that is acting as an input.

Each port is modelled as three signals: an input vector, an output vector and a per-bit drive-enable vector. The drive-enable stands in for an open-collector driver. A build-time parameter selects a true or a complemented output path. The registers always hold the true input value.

Top module: `regbus_xcvr`

## Requirements
- R1: On each rising edge of `clk_ab` while `rst_n` is 1, the A-to-B register loads `a_in`. Between edges of `clk_ab` it keeps its value, whatever `a_in` does.
- R2: On each rising edge of `clk_ba` while `rst_n` is 1, the B-to-A register loads `b_in`. Between edges of `clk_ba` it keeps its value.
- R3: Reset is synchronous and active-low. A rising edge of a register's clock with `rst_n` at 0 clears that register to all zeros. A register whose clock does not tick keeps its contents.
- R4: When `oe_n` is 1 (isolated), `a_drv` and `b_drv` are both all zeros.
- R5: When `oe_n` is 0, the drive enables depend on `dir`. With `dir` = 1, `b_drv` is all ones and `a_drv` is all zeros. With `dir` = 0, `a_drv` is all ones and `b_drv` is all zeros. The two drive enables are never non-zero at the same time.
- R6: With `sel_ab` = 0, `b_out` carries the live `a_in`. With `sel_ab` = 1, `b_out` carries the A-to-B register. In both cases the value passes through the output transform of R9.
- R7: With `sel_ba` = 0, `a_out` carries the live `b_in`. With `sel_ba` = 1, `a_out` carries the B-to-A register. In both cases the value passes through the output transform of R9.
- R8: Both registers capture regardless of `oe_n` and `dir`. This holds in isolation and in either transfer direction, for either register or both at once.
- R9: With `INVERT` = 0, the output transform is the identity. With `INVERT` = 1, each output bit is complemented, while the registers still store uncomplemented input data.
- R10: The drive enables depend only on `oe_n` and `dir`. Clock edges, select inputs and data never change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst_n | input | 1 | Synchronous active-low clear for both registers |
| oe_n | input | 1 | Active-low output enable; 1 isolates both ports |
| dir | input | 1 | 1 drives port B, 0 drives port A |
| sel_ab | input | 1 | 1 sends stored A-to-B data to `b_out`, 0 sends live `a_in` |
| sel_ba | input | 1 | 1 sends stored B-to-A data to `a_out`, 0 sends live `b_in` |
| a_in | input | WIDTH | Value sensed on port A |
| a_out | output | WIDTH | Value presented for port A |
| a_drv | output | WIDTH | Per-bit drive enable of port A |
| b_in | input | WIDTH | Value sensed on port B |
| b_out | output | WIDTH | Value presented for port B |
| b_drv | output | WIDTH | Per-bit drive enable of port B |

## Verification
The bench captures data while the ports are isolated and while the opposite port is being driven. A design that gated capture with the output enable or the direction would lose those values, and they would show up wrong once the stored select is applied. The bench then changes the inputs with both clocks held still, and also pulses reset on only one clock. A register that followed its input, or cleared on the wrong clock, would expose itself through a stored-mode output. Every combination of enable, direction and the two selects is swept, with the drive enables checked for mutual exclusion. A non-inverting and an inverting instance run side by side, which catches inversion applied at the storage stage or missing on one path.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   // Which port, if any, the transceiver drives.
   typedef enum logic [1:0] {
      XS_ISOLATE = 2'd0,
      XS_DRIVE_A = 2'd1,
      XS_DRIVE_B = 2'd2
   } xfer_side_e;

   function automatic xfer_side_e decode_side(input logic oe_n, input logic dir);
      if (oe_n)
         return XS_ISOLATE;
      else if (dir)
         return XS_DRIVE_B;
      else
         return XS_DRIVE_A;
   endfunction

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("xcvr_capture_reg: WIDTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else
         q <= d;
   end

endmodule

// File: rtl/xcvr_path_sel.sv
module xcvr_path_sel #(
   parameter int WIDTH  = 8,
   parameter int INVERT = 0
) (
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   input  logic             use_stored,
   output logic [WIDTH-1:0] y
);

   logic [WIDTH-1:0] picked;

   assign picked = use_stored ? stored : live;

   generate
      if (INVERT != 0 && INVERT != 1) begin : g_bad_invert
         $error("xcvr_path_sel: INVERT must be 0 or 1");
      end
      if (INVERT == 1) begin : g_inv
         assign y = ~picked;
      end else begin : g_true
         assign y = picked;
      end
   endgenerate

endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
   import xcvr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             oe_n,
   input  logic             dir,
   output logic [WIDTH-1:0] a_drv,
   output logic [WIDTH-1:0] b_drv
);

   xfer_side_e side;

   always_comb begin
      side  = decode_side(oe_n, dir);
      a_drv = '0;
      b_drv = '0;
      case (side)
         XS_DRIVE_A: a_drv = '1;
         XS_DRIVE_B: b_drv = '1;
         default: ;
      endcase
   end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
   parameter int WIDTH  = 8,
   parameter int INVERT = 0
) (
   input  logic             clk_ab,
   input  logic             clk_ba,
   input  logic             rst_n,
   input  logic             oe_n,
   input  logic             dir,
   input  logic             sel_ab,
   input  logic             sel_ba,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] a_drv,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic [WIDTH-1:0] b_drv
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("regbus_xcvr: WIDTH must be at least 1");
      end
      if (INVERT != 0 && INVERT != 1) begin : g_bad_invert
         $error("regbus_xcvr: INVERT must be 0 or 1");
      end
   endgenerate

   logic [WIDTH-1:0] q_ab;
   logic [WIDTH-1:0] q_ba;

   // Storage always tracks its own clock; drive state has no say (R8).
   xcvr_capture_reg #(.WIDTH(WIDTH)) u_store_ab (
      .clk   (clk_ab),
      .rst_n (rst_n),
      .d     (a_in),
      .q     (q_ab)
   );

   xcvr_capture_reg #(.WIDTH(WIDTH)) u_store_ba (
      .clk   (clk_ba),
      .rst_n (rst_n),
      .d     (b_in),
      .q     (q_ba)
   );

   xcvr_path_sel #(.WIDTH(WIDTH), .INVERT(INVERT)) u_path_ab (
      .live       (a_in),
      .stored     (q_ab),
      .use_stored (sel_ab),
      .y          (b_out)
   );

   xcvr_path_sel #(.WIDTH(WIDTH), .INVERT(INVERT)) u_path_ba (
      .live       (b_in),
      .stored     (q_ba),
      .use_stored (sel_ba),
      .y          (a_out)
   );

   xcvr_drive_ctl #(.WIDTH(WIDTH)) u_drive (
      .oe_n  (oe_n),
      .dir   (dir),
      .a_drv (a_drv),
      .b_drv (b_drv)
   );

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
   parameter int WIDTH  = 8,
   parameter int INVERT = 0
) (
   input logic             clk_ab,
   input logic             clk_ba,
   input logic             rst_n,
   input logic             oe_n,
   input logic             dir,
   input logic             sel_ab,
   input logic             sel_ba,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] a_out,
   input logic [WIDTH-1:0] a_drv,
   input logic [WIDTH-1:0] b_in,
   input logic [WIDTH-1:0] b_out,
   input logic [WIDTH-1:0] b_drv,
   input logic [WIDTH-1:0] q_ab,
   input logic [WIDTH-1:0] q_ba
);

   localparam logic [WIDTH-1:0] FLIP = (INVERT == 1) ? '1 : '0;

   assert_capture_ab_R1: assert property (@(posedge clk_ab) disable iff (!rst_n)
      rst_n |=> q_ab == $past(a_in));

   assert_capture_ba_R2: assert property (@(posedge clk_ba) disable iff (!rst_n)
      rst_n |=> q_ba == $past(b_in));

   assert_isolate_R4: assert property (@(posedge clk_ab) disable iff (!rst_n)
      oe_n |-> (a_drv == '0 && b_drv == '0));

   assert_drive_b_R5: assert property (@(posedge clk_ab) disable iff (!rst_n)
      (!oe_n && dir) |-> (b_drv == '1 && a_drv == '0));

   assert_drive_a_R5: assert property (@(posedge clk_ba) disable iff (!rst_n)
      (!oe_n && !dir) |-> (a_drv == '1 && b_drv == '0));

   assert_exclusive_R5: assert property (@(posedge clk_ab) disable iff (!rst_n)
      !((|a_drv) && (|b_drv)));

   assert_live_ab_R6: assert property (@(posedge clk_ab) disable iff (!rst_n)
      !sel_ab |-> b_out == (a_in ^ FLIP));

   assert_stored_ab_R9: assert property (@(posedge clk_ab) disable iff (!rst_n)
      sel_ab |-> b_out == (q_ab ^ FLIP));

   assert_live_ba_R7: assert property (@(posedge clk_ba) disable iff (!rst_n)
      !sel_ba |-> a_out == (b_in ^ FLIP));

   assert_stored_ba_R7: assert property (@(posedge clk_ba) disable iff (!rst_n)
      sel_ba |-> a_out == (q_ba ^ FLIP));

   assert_drive_steady_R10: assert property (@(posedge clk_ab) disable iff (!rst_n)
      ($stable(oe_n) && $stable(dir)) |-> ($stable(a_drv) && $stable(b_drv)));

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (
   .clk_ab (clk_ab),
   .clk_ba (clk_ba),
   .rst_n  (rst_n),
   .oe_n   (oe_n),
   .dir    (dir),
   .sel_ab (sel_ab),
   .sel_ba (sel_ba),
   .a_in   (a_in),
   .a_out  (a_out),
   .a_drv  (a_drv),
   .b_in   (b_in),
   .b_out  (b_out),
   .b_drv  (b_drv),
   .q_ab   (q_ab),
   .q_ba   (q_ba)
);

// File: tb/regbus_xcvr_tb.sv
module regbus_xcvr_tb;

   localparam int W = 8;

   logic clk = 1'b0;
   logic en_ab = 1'b0, en_ba = 1'b0;
   logic clk_ab, clk_ba;
   logic rst_n = 1'b0;
   logic oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b1, sel_ba = 1'b1;
   logic [W-1:0] a_in = 8'hC3, b_in = 8'h3C;
   logic [W-1:0] a_out, a_drv, b_out, b_drv;
   logic [W-1:0] ai_out, ai_drv, bi_out, bi_drv;

   always #5 clk = ~clk;
   // Gated capture clocks; enables change only while clk is low.
   assign clk_ab = clk & en_ab;
   assign clk_ba = clk & en_ba;

   regbus_xcvr #(.WIDTH(W), .INVERT(0)) u_dut (
      .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
      .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
      .b_in(b_in), .b_out(b_out), .b_drv(b_drv));

   regbus_xcvr #(.WIDTH(W), .INVERT(1)) u_dut_inv (
      .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
      .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(ai_out), .a_drv(ai_drv),
      .b_in(b_in), .b_out(bi_out), .b_drv(bi_drv));

   typedef struct {
      logic [W-1:0] a_out;
      logic [W-1:0] b_out;
      logic [W-1:0] a_drv;
      logic [W-1:0] b_drv;
      string        tag;
   } exp_t;

   exp_t sb[$];
   int n_chk = 0;
   int n_bad = 0;
   logic done = 1'b0;
   logic [W-1:0] ref_ab = '0, ref_ba = '0;

   task automatic cmp(input string what, input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Driver: apply one cycle of stimulus and queue the expected outputs.
   task automatic step(input logic t_oe_n, input logic t_dir, input logic t_sab,
                       input logic t_sba, input logic [W-1:0] ta, input logic [W-1:0] tb,
                       input logic t_eab, input logic t_eba, input string tag);
      exp_t e;
      @(negedge clk);
      oe_n = t_oe_n; dir = t_dir; sel_ab = t_sab; sel_ba = t_sba;
      a_in = ta; b_in = tb; en_ab = t_eab; en_ba = t_eba;
      @(posedge clk);
      if (t_eab) ref_ab = rst_n ? ta : '0;   // R1 R3
      if (t_eba) ref_ba = rst_n ? tb : '0;   // R2 R3
      #1;
      e.b_out = t_sab ? ref_ab : ta;         // R6
      e.a_out = t_sba ? ref_ba : tb;         // R7
      e.b_drv = (!t_oe_n && t_dir)  ? '1 : '0;  // R4 R5
      e.a_drv = (!t_oe_n && !t_dir) ? '1 : '0;
      e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: compare both variants once outputs have settled.
   initial begin
      forever begin
         @(posedge clk);
         #3;
         while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            cmp("b_out",     {e.tag, " R6"}, b_out, e.b_out);
            cmp("a_out",     {e.tag, " R7"}, a_out, e.a_out);
            cmp("b_drv",     {e.tag, " R5"}, b_drv, e.b_drv);
            cmp("a_drv",     {e.tag, " R5"}, a_drv, e.a_drv);
            cmp("inv b_out", {e.tag, " R9"}, bi_out, ~e.b_out);
            cmp("inv a_out", {e.tag, " R9"}, ai_out, ~e.a_out);
            cmp("inv b_drv", {e.tag, " R10"}, bi_drv, e.b_drv);
            cmp("inv a_drv", {e.tag, " R10"}, ai_drv, e.a_drv);
            cmp("drv overlap", {e.tag, " R5"}, W'((|a_drv) && (|b_drv)), '0);
         end
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=done");
         finish_run();
      end
   end

   initial begin
      // R3: reset clears both registers even with non-zero inputs present.
      step(1, 0, 1, 1, 8'hC3, 8'h3C, 1, 1, "R3 reset");
      step(1, 0, 1, 1, 8'hC3, 8'h3C, 1, 1, "R3 reset");
      rst_n = 1'b1;
      // R8 R4: capture while isolated, one register at a time.
      step(1, 0, 1, 1, 8'hA5, 8'h5A, 1, 0, "R8 R1 R4 iso-capture-ab");
      step(1, 0, 1, 1, 8'h00, 8'h77, 0, 1, "R8 R2 R4 iso-capture-ba");
      // R1 R2: no clock edges, inputs move, stored outputs hold.
      step(1, 1, 1, 1, 8'hFF, 8'hFF, 0, 0, "R1 R2 hold");
      step(0, 1, 1, 1, 8'h12, 8'h34, 0, 0, "R1 R2 hold");
      // R8: both registers captured while driving each direction.
      step(0, 1, 0, 0, 8'h96, 8'h69, 1, 1, "R8 store-both drive-b");
      step(0, 1, 1, 1, 8'h01, 8'h02, 0, 0, "R8 read-back");
      step(0, 0, 1, 1, 8'h3E, 8'hE3, 1, 1, "R8 store-both drive-a");
      step(0, 0, 1, 1, 8'h00, 8'h00, 0, 0, "R8 read-back");
      // Every combination of enable, direction and selects, live and stored.
      for (int i = 0; i < 32; i++) begin
         logic [4:0] c;
         c = 5'(i);
         step(c[3], c[2], c[1], c[0], 8'(i * 29 + 11), 8'(~(i * 53)),
              c[4] | c[0], c[4] ^ c[1], "R5 R6 R7 R10 sweep");
      end
      // Random mix of everything.
      for (int i = 0; i < 300; i++) begin
         logic [5:0] r;
         r = 6'($urandom);
         step(r[0], r[1], r[2], r[3], 8'($urandom), 8'($urandom), r[4], r[5],
              "R1 R2 R8 R10 random");
      end
      // R3: reset seen on only one clock leaves the other register intact.
      step(1, 0, 1, 1, 8'h44, 8'h88, 1, 1, "R3 preload");
      rst_n = 1'b0;
      step(1, 0, 1, 1, 8'hEE, 8'hDD, 1, 0, "R3 clear-ab-only");
      rst_n = 1'b1;
      step(1, 0, 1, 1, 8'h10, 8'h20, 0, 0, "R3 after-clear");
      repeat (3) @(posedge clk);
      done = 1'b1;
      finish_run();
   end

endmodule